// File: doc/BRIEF.md
# Multi-Mode DMA Channel Controller

This block is a small direct-memory-access engine with several independent channels. Each channel copies data from a 32-bit source address to a 32-bit destination address through one shared bus-master port. Every beat is a read followed by a write, so the copy runs without any processor involvement. Software sets a channel up with one configuration write. The channel then waits for its start condition. The start condition is either a one-cycle software trigger or the peripheral request line that belongs to that channel.

A channel moves its data in blocks. A block is 1 to 16 beats long, and a channel runs 1 to 65536 blocks. The beat width is byte, half-word or word, and each address advances by the beat width after every beat. Either address can instead be held fixed. The transfer mode sets how much work one start condition releases. In block mode, one start runs every block, and the bus is re-arbitrated between blocks. In burst mode, one start runs every block and the channel keeps the bus until it finishes. In demand mode, each start moves a single block.

When several channels are ready, the lowest channel index wins. When a channel finishes its last block, it raises a sticky done flag and disables itself.

Top module: `dma_ctrl`

## Requirements
- R1: After a synchronous reset, no bus request is issued and every done flag reads 0.
- R2: A configuration write (cfg_we with cfg_ch selecting the channel) arms that channel. With cfg_hw=0 only a pulse on sw_trig[ch] starts it. With cfg_hw=1 only per_req[ch] starts it. The other start source has no effect.
- R3: The cfg_size field sets the beat width: 0 = byte, 1 = half-word, 2 = word. The value 3 is treated as word. mem_size carries the same code on every request. Data sits in the low bytes of mem_wdata and mem_rdata, little-endian.
- R4: After each beat, an address advances by 1, 2 or 4 bytes to match the beat width. If cfg_src_fix or cfg_dst_fix is set, that side keeps its start address for every beat.
- R5: A cfg_blk value of k gives k+1 beats per block (1 to 16). A cfg_cnt value of n gives n+1 blocks (1 to 65536). A channel that runs to completion performs exactly (k+1)*(n+1) write beats.
- R6: cfg_mode=0 is block mode. One start runs all blocks, and a waiting lower-index channel takes the bus at the next block boundary.
- R7: cfg_mode=1 is burst mode. One start runs all blocks without giving up the bus, so a lower-index channel that becomes ready mid-run waits until the run ends.
- R8: cfg_mode=2 is demand mode. Each start moves exactly one block, and the next block waits for a new start.
- R9: When several channels are ready at an arbitration point, the lowest channel index is served first. Only one channel moves data at a time.
- R10: When the last beat of the last block is written, done[ch] rises and stays set, and the channel ignores further starts. A new configuration write to that channel clears its done flag.
- R11: A request holds mem_addr, mem_we and mem_size stable until mem_ready. Each write follows an accepted read of the same beat and carries the data that was read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel selected by the configuration write |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_mode | input | 2 | 0 block, 1 burst, 2 demand |
| cfg_size | input | 2 | 0 byte, 1 half-word, 2 word |
| cfg_blk | input | BLKW | Beats per block minus one |
| cfg_cnt | input | CNTW | Blocks per run minus one |
| cfg_src_fix | input | 1 | Hold the source address |
| cfg_dst_fix | input | 1 | Hold the destination address |
| cfg_hw | input | 1 | 1: start from peripheral request, 0: from software trigger |
| sw_trig | input | NCH | Software start pulse per channel |
| per_req | input | NCH | Peripheral request per channel |
| done | output | NCH | Sticky completion flag per channel |
| mem_req | output | 1 | Bus request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Bus accepts the current request |

## Verification
A table of copy jobs covers the three beat widths, single- and multi-beat blocks, one and many blocks (up to 300), a fixed source and a fixed destination, and a bus that stalls every third cycle. Each job is checked on destination contents, write-beat count, final write address and beat-width code. These checks separate an address step that is wrong, a block or block-count field that is off by one, and a lost beat under back-pressure. Directed sequences start a low-index channel in the middle of a higher channel's run. The write order then shows where block mode re-arbitrates and shows that burst mode does not. Further directed sequences pulse two starts in the same cycle, send demand requests one block at a time, send starts from the wrong source, and send starts after completion. These show priority order, block-per-request pacing, and start inputs that are correctly ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XM_BLOCK  = 2'd0,
    XM_BURST  = 2'd1,
    XM_DEMAND = 2'd2
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2,
    ENG_NXT  = 2'd3
  } eng_state_e;

  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int BLKW = 4,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_size,
  input  logic [BLKW-1:0] cfg_blk,
  input  logic [CNTW-1:0] cfg_cnt,
  input  logic            cfg_src_fix,
  input  logic            cfg_dst_fix,
  input  logic            cfg_hw,
  input  logic            sw_trig,
  input  logic            per_req,
  input  logic            beat_done,
  output logic            run,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   dst_addr,
  output logic [1:0]      size,
  output logic            burst,
  output logic            last_beat,
  output logic            done
);
  logic            en;
  logic            hw_q, sfix_q, dfix_q;
  xfer_mode_e      mode_q;
  logic [BLKW-1:0] blk_q, blk_left;
  logic [CNTW-1:0] cnt_left;
  logic [AW-1:0]   step;
  logic            start;

  assign step      = AW'(1) << size;
  assign start     = en && !run && (hw_q ? per_req : sw_trig);
  assign burst     = (mode_q == XM_BURST);
  assign last_beat = (blk_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      run      <= 1'b0;
      done     <= 1'b0;
      hw_q     <= 1'b0;
      sfix_q   <= 1'b0;
      dfix_q   <= 1'b0;
      mode_q   <= XM_BLOCK;
      size     <= 2'd0;
      blk_q    <= '0;
      blk_left <= '0;
      cnt_left <= '0;
      src_addr <= '0;
      dst_addr <= '0;
    end else if (cfg_we) begin
      en       <= 1'b1;
      run      <= 1'b0;
      done     <= 1'b0;
      hw_q     <= cfg_hw;
      sfix_q   <= cfg_src_fix;
      dfix_q   <= cfg_dst_fix;
      mode_q   <= (cfg_mode == 2'd3) ? XM_BLOCK : xfer_mode_e'(cfg_mode);
      size     <= (cfg_size == 2'd3) ? SZ_WORD : cfg_size;
      blk_q    <= cfg_blk;
      blk_left <= cfg_blk;
      cnt_left <= cfg_cnt;
      src_addr <= cfg_src;
      dst_addr <= cfg_dst;
    end else begin
      if (start) run <= 1'b1;
      if (beat_done) begin
        if (!sfix_q) src_addr <= src_addr + step;
        if (!dfix_q) dst_addr <= dst_addr + step;
        if (blk_left == '0) begin
          blk_left <= blk_q;
          if (cnt_left == '0) begin
            en   <= 1'b0;
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt_left <= cnt_left - 1'b1;
            if (mode_q == XM_DEMAND) run <= 1'b0;
          end
        end else begin
          blk_left <= blk_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CHW = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          run,
  input  logic                    arb_any,
  input  logic [CHW-1:0]          arb_idx,
  input  logic [NCH-1:0][AW-1:0]  src_all,
  input  logic [NCH-1:0][AW-1:0]  dst_all,
  input  logic [NCH-1:0][1:0]     size_all,
  input  logic [NCH-1:0]          burst_all,
  input  logic [NCH-1:0]          last_all,
  output logic [NCH-1:0]          beat_done,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [1:0]              mem_size,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_ready
);
  eng_state_e     state;
  logic [CHW-1:0] gch;
  logic           blk_end_q;
  logic           keep;

  assign keep = run[gch] && (!blk_end_q || burst_all[gch]);

  always_comb begin
    beat_done = '0;
    if (state == ENG_WR && mem_ready) beat_done[gch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      gch       <= '0;
      blk_end_q <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= 2'd0;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (arb_any) begin
            gch      <= arb_idx;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= src_all[arb_idx];
            mem_size <= size_all[arb_idx];
            state    <= ENG_RD;
          end
        end
        ENG_RD: begin
          if (mem_ready) begin
            mem_wdata <= mem_rdata;
            mem_we    <= 1'b1;
            mem_addr  <= dst_all[gch];
            state     <= ENG_WR;
          end
        end
        ENG_WR: begin
          if (mem_ready) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            blk_end_q <= last_all[gch];
            state     <= ENG_NXT;
          end
        end
        ENG_NXT: begin
          if (keep) begin
            mem_req  <= 1'b1;
            mem_addr <= src_all[gch];
            state    <= ENG_RD;
          end else begin
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BLKW = 4,
  parameter int CNTW = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_size,
  input  logic [BLKW-1:0] cfg_blk,
  input  logic [CNTW-1:0] cfg_cnt,
  input  logic            cfg_src_fix,
  input  logic            cfg_dst_fix,
  input  logic            cfg_hw,
  input  logic [NCH-1:0]  sw_trig,
  input  logic [NCH-1:0]  per_req,
  output logic [NCH-1:0]  done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready
);
  logic [NCH-1:0]         run, burst_all, last_all, beat_done;
  logic [NCH-1:0][AW-1:0] src_all, dst_all;
  logic [NCH-1:0][1:0]    size_all;
  logic                   arb_any;
  logic [CHW-1:0]         arb_idx;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan #(.AW(AW), .BLKW(BLKW), .CNTW(CNTW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (cfg_we && (cfg_ch == CHW'(i))),
      .cfg_src    (cfg_src),
      .cfg_dst    (cfg_dst),
      .cfg_mode   (cfg_mode),
      .cfg_size   (cfg_size),
      .cfg_blk    (cfg_blk),
      .cfg_cnt    (cfg_cnt),
      .cfg_src_fix(cfg_src_fix),
      .cfg_dst_fix(cfg_dst_fix),
      .cfg_hw     (cfg_hw),
      .sw_trig    (sw_trig[i]),
      .per_req    (per_req[i]),
      .beat_done  (beat_done[i]),
      .run        (run[i]),
      .src_addr   (src_all[i]),
      .dst_addr   (dst_all[i]),
      .size       (size_all[i]),
      .burst      (burst_all[i]),
      .last_beat  (last_all[i]),
      .done       (done[i])
    );
  end

  dma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .req(run),
    .any(arb_any),
    .idx(arb_idx)
  );

  dma_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CHW(CHW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .arb_any  (arb_any),
    .arb_idx  (arb_idx),
    .src_all  (src_all),
    .dst_all  (dst_all),
    .size_all (size_all),
    .burst_all(burst_all),
    .last_all (last_all),
    .beat_done(beat_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_size (mem_size),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_we,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] beat_done,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [1:0]     mem_size,
  input logic           mem_ready
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mem_req && done == '0));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 2'd3));

  p_one_mover_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(beat_done));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> (($past(done) & ~done) == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

  p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !$past(mem_req && mem_we)) |->
      $past(mem_req && !mem_we && mem_ready));

  p_beat_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    (beat_done != '0) |-> (mem_req && mem_we && mem_ready));
endmodule

bind dma_ctrl dma_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .done     (done),
  .beat_done(beat_done),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_size (mem_size),
  .mem_ready(mem_ready)
);

// File: tb/sim_dma_ctrl.sv
module sim_dma_ctrl;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [1:0]  cfg_mode = '0, cfg_size = '0;
  logic [3:0]  cfg_blk = '0;
  logic [15:0] cfg_cnt = '0;
  logic        cfg_src_fix = 1'b0, cfg_dst_fix = 1'b0, cfg_hw = 1'b0;
  logic [3:0]  sw_trig = '0, per_req = '0;
  logic [3:0]  done;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        mem_ready = 1'b1;
  logic        stall_en = 1'b0;

  logic [7:0]  mem [0:4095];
  logic [31:0] wlog [0:63];
  int          wr_cnt = 0;
  logic [1:0]  last_size = '0;
  int          cyc = 0;
  int          errors = 0, checks = 0;
  logic        timed_out = 1'b0;

  always #5 clk = ~clk;

  dma_ctrl #(.NCH(NCH)) u0 (.*);

  function automatic logic [7:0] pat(input logic [11:0] a);
    return 8'(a * 7 + 3);
  endfunction

  always_comb begin
    logic [11:0] ia;
    ia = mem_addr[11:0];
    mem_rdata = '0;
    mem_rdata[7:0] = mem[ia];
    if (mem_size != 2'd0) mem_rdata[15:8] = mem[ia + 12'd1];
    if (mem_size[1]) begin
      mem_rdata[23:16] = mem[ia + 12'd2];
      mem_rdata[31:24] = mem[ia + 12'd3];
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(12'(i));
    end else if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata[7:0];
      if (mem_size != 2'd0) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
      if (mem_size[1]) begin
        mem[mem_addr[11:0] + 12'd2] <= mem_wdata[23:16];
        mem[mem_addr[11:0] + 12'd3] <= mem_wdata[31:24];
      end
      wlog[wr_cnt % 64] <= mem_addr;
      last_size <= mem_size;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= !(stall_en && (cyc % 3 == 0));
  end

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic configure(input int ch, input int mode, input int size, input int blk,
                           input int cnt, input logic sfix, input logic dfix,
                           input logic hw, input int src, input int dst);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_mode = 2'(mode); cfg_size = 2'(size);
    cfg_blk = 4'(blk); cfg_cnt = 16'(cnt); cfg_src_fix = sfix; cfg_dst_fix = dfix;
    cfg_hw = hw; cfg_src = 32'(src); cfg_dst = 32'(dst);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_sw(input logic [3:0] m);
    @(negedge clk); sw_trig = m;
    @(negedge clk); sw_trig = '0;
  endtask

  task automatic pulse_req(input logic [3:0] m);
    @(negedge clk); per_req = m;
    @(negedge clk); per_req = '0;
  endtask

  task automatic wait_done(input int ch, input string req);
    int t = 0;
    while (!done[ch] && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(req, done[ch] == 1'b1 && !mem_req, {done[ch], mem_req}, 2'b10);
  endtask

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  mode;
    logic [1:0]  size;
    logic [3:0]  blk;
    logic [15:0] cnt;
    logic        sfix;
    logic        dfix;
    logic        stall;
    logic [11:0] src;
    logic [11:0] dst;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'd0, 2'd0, 2'd2, 4'd3,  16'd1,   1'b0, 1'b0, 1'b0, 12'h000, 12'h800},
    '{2'd1, 2'd1, 2'd1, 4'd0,  16'd4,   1'b0, 1'b0, 1'b0, 12'h100, 12'h900},
    '{2'd2, 2'd0, 2'd0, 4'd15, 16'd0,   1'b0, 1'b0, 1'b0, 12'h200, 12'hA00},
    '{2'd3, 2'd1, 2'd2, 4'd1,  16'd2,   1'b1, 1'b0, 1'b1, 12'h300, 12'hB00},
    '{2'd0, 2'd0, 2'd0, 4'd2,  16'd1,   1'b0, 1'b1, 1'b1, 12'h400, 12'hC00},
    '{2'd1, 2'd0, 2'd1, 4'd0,  16'd299, 1'b0, 1'b0, 1'b1, 12'h400, 12'hD00}
  };

  task automatic run_vec(input vec_t v);
    int base, beats, n, bad;
    logic [11:0] s, d, last_d;
    base  = wr_cnt;
    n     = 1 << v.size;
    beats = (int'(v.blk) + 1) * (int'(v.cnt) + 1);
    stall_en = v.stall;
    configure(v.ch, v.mode, v.size, v.blk, v.cnt, v.sfix, v.dfix, 1'b0, v.src, v.dst);
    pulse_sw(4'(1 << v.ch));
    wait_done(v.ch, "R10 done after run");
    stall_en = 1'b0;
    check("R5 write beat count", wr_cnt - base == beats, wr_cnt - base, beats);
    last_d = v.dfix ? v.dst : 12'(v.dst + (beats - 1) * n);
    check("R4 last write address", wlog[(wr_cnt - 1) % 64][11:0] == last_d,
          wlog[(wr_cnt - 1) % 64], last_d);
    check("R3 beat width code", last_size == v.size, last_size, v.size);
    bad = 0;
    for (int i = 0; i < beats; i++) begin
      s = v.sfix ? v.src : 12'(v.src + i * n);
      d = v.dfix ? v.dst : 12'(v.dst + i * n);
      if (!v.dfix || i == beats - 1)
        for (int b = 0; b < n; b++)
          if (mem[d + 12'(b)] != pat(s + 12'(b))) bad++;
    end
    check("R3 R4 R11 destination contents", bad == 0, bad, 0);
  endtask

  task automatic run_all();
    int base;
    repeat (3) @(negedge clk);
    check("R1 no request in reset", !mem_req && done == '0, {mem_req, done}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", !mem_req && done == '0, {mem_req, done}, 0);

    for (int k = 0; k < 6; k++) run_vec(VECS[k]);

    // R6: block mode lets channel 0 in at the first block boundary
    configure(1, 0, 2, 1, 3, 1'b0, 1'b0, 1'b0, 12'h000, 12'h800);
    configure(0, 0, 2, 0, 0, 1'b0, 1'b0, 1'b0, 12'h040, 12'h900);
    base = wr_cnt;
    pulse_sw(4'b0010);
    while (wr_cnt < base + 1) @(negedge clk);
    pulse_sw(4'b0001);
    wait_done(1, "R10 block run done");
    check("R6 block end before switch", wlog[(base + 1) % 64] == 32'h804, wlog[(base + 1) % 64], 32'h804);
    check("R6 R9 low channel at boundary", wlog[(base + 2) % 64] == 32'h900, wlog[(base + 2) % 64], 32'h900);

    // R7: burst mode keeps the bus for the whole run
    configure(1, 1, 2, 1, 3, 1'b0, 1'b0, 1'b0, 12'h000, 12'h800);
    configure(0, 0, 2, 0, 0, 1'b0, 1'b0, 1'b0, 12'h040, 12'h900);
    base = wr_cnt;
    pulse_sw(4'b0010);
    while (wr_cnt < base + 1) @(negedge clk);
    pulse_sw(4'b0001);
    wait_done(0, "R10 waiting channel done");
    check("R7 burst not interrupted", wlog[(base + 2) % 64] == 32'h808, wlog[(base + 2) % 64], 32'h808);
    check("R7 waiter after burst", wlog[(base + 8) % 64] == 32'h900, wlog[(base + 8) % 64], 32'h900);

    // R9: simultaneous starts on channels 3 and 1
    configure(3, 0, 2, 0, 0, 1'b0, 1'b0, 1'b0, 12'h080, 12'hA00);
    configure(1, 0, 2, 0, 0, 1'b0, 1'b0, 1'b0, 12'h0C0, 12'hA40);
    base = wr_cnt;
    pulse_sw(4'b1010);
    wait_done(3, "R10 ch3 done");
    check("R9 lowest index first", wlog[base % 64] == 32'hA40, wlog[base % 64], 32'hA40);
    check("R9 higher index second", wlog[(base + 1) % 64] == 32'hA00, wlog[(base + 1) % 64], 32'hA00);
    configure(1, 0, 2, 0, 0, 1'b0, 1'b0, 1'b0, 12'h0C0, 12'hA40);
    check("R10 cfg write clears done", done[1] == 1'b0, done[1], 0);

    // R2: software channel ignores the peripheral request
    base = wr_cnt;
    pulse_req(4'b0010);
    repeat (20) @(negedge clk);
    check("R2 per_req ignored on sw channel", wr_cnt == base && !mem_req, wr_cnt - base, 0);

    // R2 R8: hardware demand channel, 2 beats per block, 3 blocks
    configure(2, 2, 2, 1, 2, 1'b0, 1'b0, 1'b1, 12'h500, 12'hE00);
    base = wr_cnt;
    pulse_sw(4'b0100);
    repeat (20) @(negedge clk);
    check("R2 sw_trig ignored on hw channel", wr_cnt == base, wr_cnt - base, 0);
    pulse_req(4'b0100);
    repeat (30) @(negedge clk);
    check("R8 one block per request", wr_cnt - base == 2 && done[2] == 1'b0, wr_cnt - base, 2);
    pulse_req(4'b0100);
    repeat (30) @(negedge clk);
    check("R8 second block", wr_cnt - base == 4, wr_cnt - base, 4);
    pulse_req(4'b0100);
    wait_done(2, "R10 demand run done");
    check("R5 demand total beats", wr_cnt - base == 6, wr_cnt - base, 6);
    pulse_req(4'b0100);
    pulse_sw(4'b0100);
    repeat (20) @(negedge clk);
    check("R10 starts ignored after done", wr_cnt - base == 6 && !mem_req, wr_cnt - base, 6);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule